// File: doc/BRIEF.md
# Opcode Fetch Guard with Address Trap and Break Request

This block sits between an 8-bit controller core and its program bus and watches every opcode-fetch cycle in a 16-bit address space. It sorts each fetch address into one of five regions: special-function registers, data RAM, a test-ROM window, program ROM, or space with no memory behind it. It hands the core the byte that was fetched. When the fetch targets unimplemented space, it replaces the byte with the break opcode 8'hFF. A runaway program counter therefore turns into a software interrupt, which software treats as an address error.

The block decodes the break opcode into a software-interrupt request that outranks every other interrupt source. While a non-maskable interrupt is in service, the request is withheld and the core runs the opcode as a no-operation. A fetch from register or RAM space raises a one-cycle, registered address-trap reset request. Data reads and writes never trap. They are marked by a low fetch strobe.

Top module: `ftrap_guard`

## Requirements
- R1: A fetch (fetch_en high) from any address in 0x0000..0x003F makes trap_rst high on the next clock edge for exactly one cycle, provided the following cycle is not itself a trapping fetch.
- R2: A fetch from any address in 0x0040..0x083F makes trap_rst high on the next clock edge. A fetch from 0x0840 does not.
- R3: During a fetch from unimplemented space, op_data is 8'hFF whatever mem_rdata is. With default parameters, unimplemented space is 0x0840..0x3F7F.
- R4: During a fetch from the test-ROM window 0x3F80..0x3FFF or from program ROM (default 0x4000..0xFFFF), op_data equals mem_rdata and no trap follows.
- R5: When op_data is 8'hFF on a fetch outside the trap regions and nmi_active is low, swi_req is high for one cycle on the next clock edge.
- R6: When nmi_active is high in the decode cycle, a fetched 8'hFF raises no swi_req.
- R7: When fetch_en is low, no trap_rst or swi_req follows, and op_data equals mem_rdata at every address.
- R8: While rst_n is low at a clock edge, trap_rst and swi_req are low after that edge.
- R9: A fetch of 8'hFF from a trap region raises trap_rst but no swi_req.
- R10: The program-ROM start is a parameter. With ROM_LO = 0x8000, a fetch from 0x4000 is unimplemented and returns 8'hFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| fetch_en | input | 1 | High during an opcode-fetch cycle |
| addr | input | 16 | Bus address |
| mem_rdata | input | 8 | Byte returned by the memory arrays |
| nmi_active | input | 1 | Non-maskable interrupt currently in service |
| op_data | output | 8 | Byte passed to the core |
| swi_req | output | 1 | One-cycle software-interrupt request, top priority |
| trap_rst | output | 1 | One-cycle address-trap reset request |

## Verification
The bench builds two copies of the block. One uses the default map, so every region edge is reachable: 0x003F/0x0040, 0x083F/0x0840, 0x3F7F/0x3F80 and 0x3FFF/0x4000, plus the top address 0xFFFF. The second copy moves the ROM start to 0x8000. This shows that the unimplemented gap follows the parameter and that 0x4000 then yields the break opcode.

// File: rtl/ftrap_pkg.sv
// Shared types for the fetch guard.
// Assumes: one region code per fetch address; the decoder resolves overlaps by priority.
package ftrap_pkg;

    typedef enum logic [2:0] {
        RG_SFR   = 3'd0,
        RG_RAM   = 3'd1,
        RG_TEST  = 3'd2,
        RG_ROM   = 3'd3,
        RG_UNIMP = 3'd4
    } region_e;

    // True for regions where executing code is a fault.
    function automatic logic is_trap_region(input region_e rg);
        return (rg == RG_SFR) || (rg == RG_RAM);
    endfunction

endpackage

// File: rtl/ftrap_region_decode.sv
// Classifies an address into a memory region.
// Assumes: register space starts at address zero; the priority order is
// registers, RAM, test window, ROM, and anything left over is unimplemented.
module ftrap_region_decode
    import ftrap_pkg::*;
#(
    parameter int          AW      = 16,
    parameter logic [AW-1:0] SFR_HI  = 16'h003F,
    parameter logic [AW-1:0] RAM_LO  = 16'h0040,
    parameter logic [AW-1:0] RAM_HI  = 16'h083F,
    parameter bit          TEST_EN = 1'b1,
    parameter logic [AW-1:0] TEST_LO = 16'h3F80,
    parameter logic [AW-1:0] TEST_HI = 16'h3FFF,
    parameter logic [AW-1:0] ROM_LO  = 16'h4000,
    parameter logic [AW-1:0] ROM_HI  = 16'hFFFF
) (
    input  logic [AW-1:0] addr,
    output region_e       region
);

    logic in_sfr, in_ram, in_test, in_rom;

    // Range compares for the fixed regions.
    always_comb begin
        in_sfr = (addr <= SFR_HI);
        in_ram = (addr >= RAM_LO) && (addr <= RAM_HI);
        in_rom = (addr >= ROM_LO) && (addr <= ROM_HI);
    end

    // The test window exists only when the parameter asks for it.
    generate
        if (TEST_EN) begin : g_test
            always_comb in_test = (addr >= TEST_LO) && (addr <= TEST_HI);
        end else begin : g_no_test
            always_comb in_test = 1'b0;
        end
    endgenerate

    // Priority resolution into a single region code.
    always_comb begin
        if (in_sfr)       region = RG_SFR;
        else if (in_ram)  region = RG_RAM;
        else if (in_test) region = RG_TEST;
        else if (in_rom)  region = RG_ROM;
        else              region = RG_UNIMP;
    end

endmodule

// File: rtl/ftrap_opcode_mux.sv
// Supplies the byte seen by the core, forcing the break opcode on fetches
// from unimplemented space.
// Assumes: data cycles (fetch_en low) always pass the bus byte unchanged.
module ftrap_opcode_mux
    import ftrap_pkg::*;
#(
    parameter int            DW     = 8,
    parameter logic [DW-1:0] SWI_OP = 8'hFF
) (
    input  logic          fetch_en,
    input  region_e       region,
    input  logic [DW-1:0] mem_rdata,
    output logic [DW-1:0] op_data
);

    // Substitute on an unimplemented fetch, otherwise pass through.
    always_comb begin
        if (fetch_en && (region == RG_UNIMP)) op_data = SWI_OP;
        else                                  op_data = mem_rdata;
    end

endmodule

// File: rtl/ftrap_swi_ctl.sv
// Turns a decoded break opcode into a one-cycle software-interrupt request.
// Assumes: NMI status is valid in the decode cycle; trapping fetches defer to reset.
module ftrap_swi_ctl
    import ftrap_pkg::*;
#(
    parameter int            DW     = 8,
    parameter logic [DW-1:0] SWI_OP = 8'hFF
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          fetch_en,
    input  region_e       region,
    input  logic [DW-1:0] op_data,
    input  logic          nmi_active,
    output logic          swi_req
);

    logic swi_hit;

    // Break opcode seen on a legal fetch while no NMI is in service.
    always_comb swi_hit = fetch_en && (op_data == SWI_OP)
                          && !is_trap_region(region) && !nmi_active;

    // Register the request so it lasts exactly one cycle per decode.
    always_ff @(posedge clk) begin
        if (!rst_n) swi_req <= 1'b0;
        else        swi_req <= swi_hit;
    end

endmodule

// File: rtl/ftrap_reset_gen.sv
// Raises a registered address-trap reset request on code fetch from data areas.
// Assumes: only opcode fetches trap; data accesses never do.
module ftrap_reset_gen
    import ftrap_pkg::*;
(
    input  logic    clk,
    input  logic    rst_n,
    input  logic    fetch_en,
    input  region_e region,
    output logic    trap_rst
);

    // One-cycle pulse following each trapping fetch.
    always_ff @(posedge clk) begin
        if (!rst_n) trap_rst <= 1'b0;
        else        trap_rst <= fetch_en && is_trap_region(region);
    end

endmodule

// File: rtl/ftrap_guard.sv
// Top of the fetch guard: region decode, opcode substitution, break request
// and address-trap reset.
// Assumes: a single-cycle fetch strobe; memory data valid in the fetch cycle.
module ftrap_guard
    import ftrap_pkg::*;
#(
    parameter int            AW      = 16,
    parameter int            DW      = 8,
    parameter logic [DW-1:0] SWI_OP  = 8'hFF,
    parameter logic [AW-1:0] SFR_HI  = 16'h003F,
    parameter logic [AW-1:0] RAM_LO  = 16'h0040,
    parameter logic [AW-1:0] RAM_HI  = 16'h083F,
    parameter bit            TEST_EN = 1'b1,
    parameter logic [AW-1:0] TEST_LO = 16'h3F80,
    parameter logic [AW-1:0] TEST_HI = 16'h3FFF,
    parameter logic [AW-1:0] ROM_LO  = 16'h4000,
    parameter logic [AW-1:0] ROM_HI  = 16'hFFFF
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          fetch_en,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] mem_rdata,
    input  logic          nmi_active,
    output logic [DW-1:0] op_data,
    output logic          swi_req,
    output logic          trap_rst
);

    region_e region;

    ftrap_region_decode #(
        .AW(AW), .SFR_HI(SFR_HI), .RAM_LO(RAM_LO), .RAM_HI(RAM_HI),
        .TEST_EN(TEST_EN), .TEST_LO(TEST_LO), .TEST_HI(TEST_HI),
        .ROM_LO(ROM_LO), .ROM_HI(ROM_HI)
    ) u_decode (
        .addr   (addr),
        .region (region)
    );

    ftrap_opcode_mux #(.DW(DW), .SWI_OP(SWI_OP)) u_mux (
        .fetch_en  (fetch_en),
        .region    (region),
        .mem_rdata (mem_rdata),
        .op_data   (op_data)
    );

    ftrap_swi_ctl #(.DW(DW), .SWI_OP(SWI_OP)) u_swi (
        .clk        (clk),
        .rst_n      (rst_n),
        .fetch_en   (fetch_en),
        .region     (region),
        .op_data    (op_data),
        .nmi_active (nmi_active),
        .swi_req    (swi_req)
    );

    ftrap_reset_gen u_trap (
        .clk      (clk),
        .rst_n    (rst_n),
        .fetch_en (fetch_en),
        .region   (region),
        .trap_rst (trap_rst)
    );

endmodule

// File: rtl/ftrap_guard_chk.sv
// Property checker for the fetch guard, attached through bind.
// Assumes: the same address map parameters as the guard instance it watches.
module ftrap_guard_chk #(
    parameter int            AW      = 16,
    parameter int            DW      = 8,
    parameter logic [DW-1:0] SWI_OP  = 8'hFF,
    parameter logic [AW-1:0] SFR_HI  = 16'h003F,
    parameter logic [AW-1:0] RAM_LO  = 16'h0040,
    parameter logic [AW-1:0] RAM_HI  = 16'h083F,
    parameter bit            TEST_EN = 1'b1,
    parameter logic [AW-1:0] TEST_LO = 16'h3F80,
    parameter logic [AW-1:0] TEST_HI = 16'h3FFF,
    parameter logic [AW-1:0] ROM_LO  = 16'h4000,
    parameter logic [AW-1:0] ROM_HI  = 16'hFFFF
) (
    input logic          clk,
    input logic          rst_n,
    input logic          fetch_en,
    input logic [AW-1:0] addr,
    input logic [DW-1:0] mem_rdata,
    input logic          nmi_active,
    input logic [DW-1:0] op_data,
    input logic          swi_req,
    input logic          trap_rst
);

    logic a_sfr, a_ram, a_test, a_rom, a_unimp;

    // Independent view of the map taken from the ports.
    always_comb begin
        a_sfr   = (addr <= SFR_HI);
        a_ram   = (addr >= RAM_LO) && (addr <= RAM_HI);
        a_test  = TEST_EN && (addr >= TEST_LO) && (addr <= TEST_HI);
        a_rom   = (addr >= ROM_LO) && (addr <= ROM_HI);
        a_unimp = !a_sfr && !a_ram && !a_test && !a_rom;
    end

    p_trap_sfr_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (fetch_en && a_sfr) |=> trap_rst);

    p_trap_ram_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (fetch_en && a_ram && !a_sfr) |=> trap_rst);

    p_unimp_break_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (fetch_en && a_unimp) |-> (op_data == SWI_OP));

    p_rom_pass_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (fetch_en && !a_sfr && !a_ram && (a_test || a_rom)) |-> (op_data == mem_rdata));

    p_swi_raise_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (fetch_en && !a_sfr && !a_ram && !nmi_active && op_data == SWI_OP) |=> swi_req);

    p_swi_nmi_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (fetch_en && nmi_active) |=> !swi_req);

    p_idle_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !fetch_en |=> (!swi_req && !trap_rst));

    p_reset_clear_r8: assert property (@(posedge clk)
        !rst_n |=> (!swi_req && !trap_rst));

    p_trap_no_swi_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (fetch_en && (a_sfr || a_ram)) |=> !swi_req);

endmodule

bind ftrap_guard ftrap_guard_chk #(
    .AW(AW), .DW(DW), .SWI_OP(SWI_OP), .SFR_HI(SFR_HI),
    .RAM_LO(RAM_LO), .RAM_HI(RAM_HI), .TEST_EN(TEST_EN),
    .TEST_LO(TEST_LO), .TEST_HI(TEST_HI), .ROM_LO(ROM_LO), .ROM_HI(ROM_HI)
) u_chk (
    .clk(clk), .rst_n(rst_n), .fetch_en(fetch_en), .addr(addr),
    .mem_rdata(mem_rdata), .nmi_active(nmi_active), .op_data(op_data),
    .swi_req(swi_req), .trap_rst(trap_rst)
);

// File: tb/ftrap_guard_test.sv
// Directed bench for the fetch guard: one task per scenario.
module ftrap_guard_test;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        fetch_en = 1'b0;
    logic [15:0] addr = '0;
    logic [7:0]  mem_rdata = '0;
    logic        nmi_active = 1'b0;
    logic [7:0]  op_data, op_data_n;
    logic        swi_req, trap_rst, swi_req_n, trap_rst_n;

    int total = 0;
    int fails = 0;
    bit done = 1'b0;

    logic [7:0] op_c, op_cn;
    logic       swi_c, trap_c;

    always #(CLK_PERIOD/2) clk = ~clk;

    ftrap_guard uut (
        .clk(clk), .rst_n(rst_n), .fetch_en(fetch_en), .addr(addr),
        .mem_rdata(mem_rdata), .nmi_active(nmi_active),
        .op_data(op_data), .swi_req(swi_req), .trap_rst(trap_rst)
    );

    ftrap_guard #(.ROM_LO(16'h8000)) uut_nr (
        .clk(clk), .rst_n(rst_n), .fetch_en(fetch_en), .addr(addr),
        .mem_rdata(mem_rdata), .nmi_active(nmi_active),
        .op_data(op_data_n), .swi_req(swi_req_n), .trap_rst(trap_rst_n)
    );

    task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
        total++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // Drive one cycle; capture the combinational byte and the registered outcome.
    task automatic cyc(input logic fe, input logic [15:0] a, input logic [7:0] d, input logic nmi);
        @(negedge clk);
        fetch_en = fe; addr = a; mem_rdata = d; nmi_active = nmi;
        #1;
        op_c = op_data; op_cn = op_data_n;
        @(posedge clk);
        #1;
        swi_c = swi_req; trap_c = trap_rst;
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        cyc(1'b1, 16'h0010, 8'h00, 1'b0);
        chk("R8 trap low in reset", {15'd0, trap_c}, 16'd0);
        chk("R8 swi low in reset", {15'd0, swi_c}, 16'd0);
        @(negedge clk); rst_n = 1'b1;
    endtask

    task automatic t_sfr();
        cyc(1'b1, 16'h0000, 8'h12, 1'b0);
        chk("R1 trap at 0000", {15'd0, trap_c}, 16'd1);
        cyc(1'b1, 16'h003F, 8'h12, 1'b0);
        chk("R1 trap at 003F", {15'd0, trap_c}, 16'd1);
        cyc(1'b0, 16'h4000, 8'h00, 1'b0);
        chk("R1 pulse ends", {15'd0, trap_c}, 16'd0);
    endtask

    task automatic t_ram();
        cyc(1'b1, 16'h0040, 8'h34, 1'b0);
        chk("R2 trap at 0040", {15'd0, trap_c}, 16'd1);
        cyc(1'b1, 16'h083F, 8'h34, 1'b0);
        chk("R2 trap at 083F", {15'd0, trap_c}, 16'd1);
        cyc(1'b1, 16'h0840, 8'h34, 1'b0);
        chk("R2 no trap at 0840", {15'd0, trap_c}, 16'd0);
    endtask

    task automatic t_unimp();
        cyc(1'b1, 16'h0840, 8'h5A, 1'b0);
        chk("R3 break at 0840", {8'd0, op_c}, 16'h00FF);
        chk("R5 unimp fetch raises swi", {15'd0, swi_c}, 16'd1);
        cyc(1'b1, 16'h3F7F, 8'h00, 1'b0);
        chk("R3 break at 3F7F", {8'd0, op_c}, 16'h00FF);
    endtask

    task automatic t_rom();
        cyc(1'b1, 16'h3F80, 8'hA5, 1'b0);
        chk("R4 test window 3F80 passes", {8'd0, op_c}, 16'h00A5);
        chk("R4 no trap 3F80", {15'd0, trap_c}, 16'd0);
        cyc(1'b1, 16'h3FFF, 8'h3C, 1'b0);
        chk("R4 test window 3FFF passes", {8'd0, op_c}, 16'h003C);
        cyc(1'b1, 16'h4000, 8'h77, 1'b0);
        chk("R4 rom 4000 passes", {8'd0, op_c}, 16'h0077);
        chk("R10 narrow map 4000 breaks", {8'd0, op_cn}, 16'h00FF);
        cyc(1'b1, 16'hFFFF, 8'h81, 1'b0);
        chk("R4 rom FFFF passes", {8'd0, op_c}, 16'h0081);
        chk("R4 no swi for non-break", {15'd0, swi_c}, 16'd0);
    endtask

    task automatic t_swi();
        cyc(1'b1, 16'h5000, 8'hFF, 1'b0);
        chk("R5 swi from rom break", {15'd0, swi_c}, 16'd1);
        cyc(1'b1, 16'h5001, 8'h00, 1'b0);
        chk("R5 swi one cycle", {15'd0, swi_c}, 16'd0);
        cyc(1'b1, 16'h5002, 8'hFF, 1'b1);
        chk("R6 swi held off under nmi", {15'd0, swi_c}, 16'd0);
        cyc(1'b1, 16'h1000, 8'h00, 1'b1);
        chk("R6 unimp under nmi no swi", {15'd0, swi_c}, 16'd0);
    endtask

    task automatic t_trap_ff();
        cyc(1'b1, 16'h0100, 8'hFF, 1'b0);
        chk("R9 trap on ram break", {15'd0, trap_c}, 16'd1);
        chk("R9 no swi on ram break", {15'd0, swi_c}, 16'd0);
    endtask

    task automatic t_nofetch();
        cyc(1'b0, 16'h0010, 8'h22, 1'b0);
        chk("R7 sfr data access no trap", {15'd0, trap_c}, 16'd0);
        cyc(1'b0, 16'h0500, 8'hFF, 1'b0);
        chk("R7 ram data access no trap", {15'd0, trap_c}, 16'd0);
        chk("R7 data FF no swi", {15'd0, swi_c}, 16'd0);
        cyc(1'b0, 16'h2000, 8'h66, 1'b0);
        chk("R7 unimp data read passes", {8'd0, op_c}, 16'h0066);
        chk("R7 unimp data read no swi", {15'd0, swi_c}, 16'd0);
    endtask

    initial begin
        t_reset();
        t_sfr();
        t_ram();
        t_unimp();
        t_rom();
        t_swi();
        t_trap_ff();
        t_nofetch();
        done = 1'b1;
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            total++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", total - fails, total);
            $finish;
        end
    end

endmodule